// File: doc/BRIEF.md
# Multi-Channel DMA Register Decoder

This block is the front door to the register space of a sixteen-channel DMA controller. It has two request windows. The main window is 4 KiB wide. Within it, channels 0 to 14 each own a 256-byte slice, and two global words sit near the top: the interrupt status word and the channel enable word. Channel 15 has no slice in the main window. It is reached only through a small auxiliary window of 256 bytes.

The decoder accepts one access at a time from either window. It turns each access into a one-cycle read or write strobe on the chosen channel's register port, or serves the access itself from its global words. It then returns the read data on that window's response channel. The decoder owns the per-channel enable vector. It also keeps a registered copy of the per-channel interrupt flags, which it refreshes on every clock.

Both windows use valid/ready handshakes. A request is taken on a cycle where req_valid and req_ready are both high. A response is held stable until rsp_ready is high. A window does not take a new request while its own response is stalled, so each window has at most one response in flight. When both windows request in the same cycle, the main window goes first and the auxiliary window waits.

Top module: `dma_reg_decoder`

## Requirements
- R1: For a main-window access with offset below 0xF00, the channel is offset bits [11:8] and the register offset is bits [7:0]. In the accept cycle, exactly that channel's read or write strobe is high, ch_addr carries bits [7:0] and ch_wdata carries the write data.
- R2: Main offset 0xFE0 reads the interrupt status word: bits [15:0] hold one bit per channel and bits [31:16] are zero. Writes to 0xFE0 change nothing and raise no strobe.
- R3: Main offset 0xFF0 is the enable word. A write loads bits [15:0] and discards bits [31:16]. A read returns the enable bits zero-extended. ch_enable shows the new value from the cycle after the write is accepted.
- R4: After reset, ch_enable is 0xFFFF, the status word reads 0, and neither response is valid.
- R5: Every auxiliary-window access goes to channel 15, using auxiliary address bits [7:0] as the register offset. No main-window access ever strobes channel 15.
- R6: An access whose byte strobe is not 4'b1111 is still accepted and answered. It raises no channel strobe, changes no global word, and reads as zero.
- R7: Main offsets at or above 0xF00, other than 0xFE0 and 0xFF0, read as zero and ignore writes.
- R8: While the main window has a request pending, the auxiliary window's req_ready is low. The auxiliary request is taken on the first cycle the main window is idle.
- R9: The response appears in the cycle after acceptance. While rsp_valid is high and rsp_ready is low, the response data stays unchanged and that window's req_ready is low.
- R10: The status word read in a given cycle holds the ch_irq value sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req_valid | input | 1 | Main window request valid |
| m_req_ready | output | 1 | Main window request ready |
| m_req_write | input | 1 | Main request is a write |
| m_req_addr | input | 12 | Main window byte offset |
| m_req_wdata | input | 32 | Main write data |
| m_req_strb | input | 4 | Main byte strobes |
| m_rsp_valid | output | 1 | Main response valid |
| m_rsp_ready | input | 1 | Main response ready |
| m_rsp_rdata | output | 32 | Main read data |
| a_req_valid | input | 1 | Auxiliary window request valid |
| a_req_ready | output | 1 | Auxiliary window request ready |
| a_req_write | input | 1 | Auxiliary request is a write |
| a_req_addr | input | 8 | Auxiliary window byte offset |
| a_req_wdata | input | 32 | Auxiliary write data |
| a_req_strb | input | 4 | Auxiliary byte strobes |
| a_rsp_valid | output | 1 | Auxiliary response valid |
| a_rsp_ready | input | 1 | Auxiliary response ready |
| a_rsp_rdata | output | 32 | Auxiliary read data |
| ch_rd | output | 16 | Per-channel register read strobe |
| ch_wr | output | 16 | Per-channel register write strobe |
| ch_addr | output | 8 | Register offset within the channel |
| ch_wdata | output | 32 | Write data to the channel |
| ch_rdata | input | 512 | Read data from each channel, channel c in bits [32c+31:32c] |
| ch_irq | input | 16 | Interrupt flag from each channel |
| ch_enable | output | 16 | Enable bit for each channel |

## Verification
The hardest case to reach is a collision on the shared channel port. It happens when the main window is stalled on its response while a new main request and an auxiliary request are both waiting. In that state the main window holds the port without being able to use it, and the auxiliary window still has to yield. The stimulus reaches it in stages. It first holds m_rsp_ready low after a main read. It then raises a second main request and an auxiliary request together, checks that neither is taken and that no strobe fires, and finally releases the response so the main request, and after it the auxiliary one, go through. The one-cycle lag of the status word is caught by changing ch_irq in the same cycle a status read is accepted.

// File: rtl/dmadec_pkg.sv
package dmadec_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CHAN = 2'd1,
    TGT_STAT = 2'd2,
    TGT_EN   = 2'd3
  } dd_target_e;

  localparam logic [11:0] CHAN_SPAN_END = 12'hF00;
  localparam logic [11:0] STAT_OFFSET   = 12'hFE0;
  localparam logic [11:0] EN_OFFSET     = 12'hFF0;
endpackage

// File: rtl/dmadec_addr_map.sv
module dmadec_addr_map
  import dmadec_pkg::*;
#(
  parameter int AW     = 12,
  parameter int REG_AW = 8,
  parameter int NCH    = 16,
  parameter int STRB_W = 4,
  parameter bit IS_AUX = 1'b0,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic [AW-1:0]     addr,
  input  logic [STRB_W-1:0] strb,
  output dd_target_e        tgt,
  output logic [CHW-1:0]    chan,
  output logic [REG_AW-1:0] off
);
  logic full_word;
  assign full_word = &strb;

  generate
    if (IS_AUX) begin : g_aux
      always_comb begin
        off  = addr[REG_AW-1:0];
        chan = CHW'(NCH - 1);
        tgt  = full_word ? TGT_CHAN : TGT_NONE;
      end
    end else begin : g_main
      always_comb begin
        off  = addr[REG_AW-1:0];
        chan = addr[REG_AW +: CHW];
        tgt  = TGT_NONE;
        if (full_word) begin
          if (addr < CHAN_SPAN_END)   tgt = TGT_CHAN;
          else if (addr == STAT_OFFSET) tgt = TGT_STAT;
          else if (addr == EN_OFFSET)   tgt = TGT_EN;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dmadec_port.sv
module dmadec_port #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          grant,
  output logic          req_ready,
  output logic          accept,
  input  logic [DW-1:0] rd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);
  assign req_ready = grant && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !accept);
endmodule

// File: rtl/dmadec_global.sv
module dmadec_global #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_wr,
  input  logic [NCH-1:0] en_wdata,
  input  logic [NCH-1:0] irq_in,
  output logic [NCH-1:0] enable_q,
  output logic [NCH-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '1;
      status_q <= '0;
    end else begin
      status_q <= irq_in;
      if (en_wr) enable_q <= en_wdata;
    end
  end

  assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(enable_q));
endmodule

// File: rtl/dma_reg_decoder.sv
module dma_reg_decoder
  import dmadec_pkg::*;
#(
  parameter int NCH     = 16,
  parameter int DW      = 32,
  parameter int MAIN_AW = 12,
  parameter int REG_AW  = 8,
  localparam int STRB_W = DW / 8,
  localparam int CHW    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_req_valid,
  output logic              m_req_ready,
  input  logic              m_req_write,
  input  logic [MAIN_AW-1:0] m_req_addr,
  input  logic [DW-1:0]     m_req_wdata,
  input  logic [STRB_W-1:0] m_req_strb,
  output logic              m_rsp_valid,
  input  logic              m_rsp_ready,
  output logic [DW-1:0]     m_rsp_rdata,
  input  logic              a_req_valid,
  output logic              a_req_ready,
  input  logic              a_req_write,
  input  logic [REG_AW-1:0] a_req_addr,
  input  logic [DW-1:0]     a_req_wdata,
  input  logic [STRB_W-1:0] a_req_strb,
  output logic              a_rsp_valid,
  input  logic              a_rsp_ready,
  output logic [DW-1:0]     a_rsp_rdata,
  output logic [NCH-1:0]    ch_rd,
  output logic [NCH-1:0]    ch_wr,
  output logic [REG_AW-1:0] ch_addr,
  output logic [DW-1:0]     ch_wdata,
  input  logic [NCH*DW-1:0] ch_rdata,
  input  logic [NCH-1:0]    ch_irq,
  output logic [NCH-1:0]    ch_enable
);
  dd_target_e        m_tgt, a_tgt, sel_tgt;
  logic [CHW-1:0]    m_chan, a_chan, sel_chan;
  logic [REG_AW-1:0] m_off, a_off;
  logic              m_accept, a_accept, sel_valid, sel_write;
  logic [DW-1:0]     rd_mux;
  logic [NCH-1:0]    status_q;
  logic              en_wr;

  dmadec_addr_map #(.AW(MAIN_AW), .REG_AW(REG_AW), .NCH(NCH), .STRB_W(STRB_W), .IS_AUX(1'b0))
    u_map_main (.addr(m_req_addr), .strb(m_req_strb), .tgt(m_tgt), .chan(m_chan), .off(m_off));

  dmadec_addr_map #(.AW(REG_AW), .REG_AW(REG_AW), .NCH(NCH), .STRB_W(STRB_W), .IS_AUX(1'b1))
    u_map_aux (.addr(a_req_addr), .strb(a_req_strb), .tgt(a_tgt), .chan(a_chan), .off(a_off));

  dmadec_port #(.DW(DW)) u_port_main (
    .clk(clk), .rst_n(rst_n), .req_valid(m_req_valid), .grant(1'b1),
    .req_ready(m_req_ready), .accept(m_accept), .rd_data(rd_mux),
    .rsp_valid(m_rsp_valid), .rsp_ready(m_rsp_ready), .rsp_rdata(m_rsp_rdata));

  dmadec_port #(.DW(DW)) u_port_aux (
    .clk(clk), .rst_n(rst_n), .req_valid(a_req_valid), .grant(!m_req_valid),
    .req_ready(a_req_ready), .accept(a_accept), .rd_data(rd_mux),
    .rsp_valid(a_rsp_valid), .rsp_ready(a_rsp_ready), .rsp_rdata(a_rsp_rdata));

  always_comb begin
    sel_valid = m_accept || a_accept;
    if (m_accept) begin
      sel_tgt   = m_tgt;
      sel_chan  = m_chan;
      sel_write = m_req_write;
      ch_addr   = m_off;
      ch_wdata  = m_req_wdata;
    end else begin
      sel_tgt   = a_tgt;
      sel_chan  = a_chan;
      sel_write = a_req_write;
      ch_addr   = a_off;
      ch_wdata  = a_req_wdata;
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_strobe
      logic hit;
      assign hit      = sel_valid && (sel_tgt == TGT_CHAN) && (sel_chan == CHW'(c));
      assign ch_rd[c] = hit && !sel_write;
      assign ch_wr[c] = hit && sel_write;
    end
  endgenerate

  always_comb begin
    unique case (sel_tgt)
      TGT_CHAN: rd_mux = ch_rdata[sel_chan*DW +: DW];
      TGT_STAT: rd_mux = DW'(status_q);
      TGT_EN:   rd_mux = DW'(ch_enable);
      default:  rd_mux = '0;
    endcase
  end

  assign en_wr = sel_valid && sel_write && (sel_tgt == TGT_EN);

  dmadec_global #(.NCH(NCH)) u_global (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(ch_wdata[NCH-1:0]),
    .irq_in(ch_irq), .enable_q(ch_enable), .status_q(status_q));

  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rd | ch_wr));

  assert_aux_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid |-> !a_req_ready);

  assert_ch15_aux_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_accept |-> (!ch_rd[NCH-1] && !ch_wr[NCH-1]));

  assert_bad_size_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_accept && !(&m_req_strb)) |-> ((ch_rd | ch_wr) == '0));
endmodule

// File: tb/dma_reg_decoder_tb.sv
module dma_reg_decoder_tb;
  localparam int NCH = 16;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic m_req_valid = 0, m_req_write = 0, m_rsp_ready = 1;
  logic [11:0] m_req_addr = 0;
  logic [31:0] m_req_wdata = 0;
  logic [3:0]  m_req_strb = 4'hF;
  logic a_req_valid = 0, a_req_write = 0, a_rsp_ready = 1;
  logic [7:0]  a_req_addr = 0;
  logic [31:0] a_req_wdata = 0;
  logic [3:0]  a_req_strb = 4'hF;
  logic m_req_ready, m_rsp_valid, a_req_ready, a_rsp_valid;
  logic [31:0] m_rsp_rdata, a_rsp_rdata, ch_wdata;
  logic [NCH-1:0] ch_rd, ch_wr, ch_enable;
  logic [NCH-1:0] ch_irq = 0;
  logic [7:0] ch_addr;
  logic [NCH*32-1:0] ch_rdata;

  dma_reg_decoder u_dut (.*);

  function automatic logic [31:0] chan_word(int c, logic [7:0] off);
    return {8'(c), 8'h5A, 8'h00, off};
  endfunction

  always_comb begin
    for (int c = 0; c < NCH; c++) ch_rdata[c*32 +: 32] = chan_word(c, ch_addr);
  end

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] model_en = 16'hFFFF;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock reference comparison of the enable vector
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      #2 chk("R3 enable model", 32'(ch_enable), 32'(model_en));
    end
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // single main access; returns strobes seen in accept cycle and response data
  task automatic main_xfer(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                           input logic [3:0] strb, output logic [NCH-1:0] rd_s,
                           output logic [NCH-1:0] wr_s, output logic [7:0] off_s,
                           output logic [31:0] rdata);
    @(negedge clk);
    m_req_valid = 1; m_req_write = wr; m_req_addr = addr; m_req_wdata = wd; m_req_strb = strb;
    #1;
    rd_s = ch_rd; wr_s = ch_wr; off_s = ch_addr;
    @(posedge clk);
    if (wr && strb == 4'hF && addr == 12'hFF0) model_en = wd[15:0];
    @(negedge clk);
    m_req_valid = 0; m_req_strb = 4'hF;
    #1;
    chk("R9 rsp valid next cycle", 32'(m_rsp_valid), 32'd1);
    rdata = m_rsp_rdata;
  endtask

  task automatic aux_xfer(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                          input logic [3:0] strb, output logic [NCH-1:0] rd_s,
                          output logic [NCH-1:0] wr_s, output logic [31:0] rdata);
    @(negedge clk);
    a_req_valid = 1; a_req_write = wr; a_req_addr = addr; a_req_wdata = wd; a_req_strb = strb;
    #1;
    rd_s = ch_rd; wr_s = ch_wr;
    @(posedge clk);
    @(negedge clk);
    a_req_valid = 0; a_req_strb = 4'hF;
    #1;
    chk("R9 aux rsp valid", 32'(a_rsp_valid), 32'd1);
    rdata = a_rsp_rdata;
  endtask

  initial begin
    logic [NCH-1:0] rs, ws;
    logic [7:0] off;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R4 reset state
    chk("R4 enable reset", 32'(ch_enable), 32'h0000FFFF);
    chk("R4 m_rsp_valid reset", 32'(m_rsp_valid), 0);
    chk("R4 a_rsp_valid reset", 32'(a_rsp_valid), 0);
    main_xfer(0, 12'hFE0, 0, 4'hF, rs, ws, off, rd);
    chk("R4 status reset", rd, 0);

    // R1 channel write and read in the main window
    main_xfer(1, 12'h324, 32'hDEADBEEF, 4'hF, rs, ws, off, rd);
    chk("R1 write strobe ch3", 32'(ws), 32'h0008);
    chk("R1 no read strobe", 32'(rs), 0);
    chk("R1 offset", 32'(off), 32'h24);
    main_xfer(0, 12'hE10, 0, 4'hF, rs, ws, off, rd);
    chk("R1 read strobe ch14", 32'(rs), 32'h4000);
    chk("R1 read data ch14", rd, chan_word(14, 8'h10));
    main_xfer(0, 12'h0FC, 0, 4'hF, rs, ws, off, rd);
    chk("R1 read data ch0", rd, chan_word(0, 8'hFC));

    // R3 enable word
    main_xfer(1, 12'hFF0, 32'hABCD1234, 4'hF, rs, ws, off, rd);
    chk("R3 no channel strobe", 32'(rs | ws), 0);
    main_xfer(0, 12'hFF0, 0, 4'hF, rs, ws, off, rd);
    chk("R3 enable readback", rd, 32'h00001234);

    // R6 partial strobes ignored
    main_xfer(1, 12'hFF0, 32'h00005555, 4'h3, rs, ws, off, rd);
    main_xfer(0, 12'h200, 0, 4'h1, rs, ws, off, rd);
    chk("R6 no strobe partial", 32'(rs | ws), 0);
    chk("R6 partial read zero", rd, 0);
    main_xfer(0, 12'hFF0, 0, 4'hF, rs, ws, off, rd);
    chk("R6 enable unchanged", rd, 32'h00001234);

    // R7 other high offsets
    main_xfer(1, 12'hF00, 32'hFFFFFFFF, 4'hF, rs, ws, off, rd);
    chk("R7 no strobe at F00", 32'(rs | ws), 0);
    main_xfer(0, 12'hF00, 0, 4'hF, rs, ws, off, rd);
    chk("R7 F00 reads zero", rd, 0);
    main_xfer(0, 12'hFFC, 0, 4'hF, rs, ws, off, rd);
    chk("R7 FFC reads zero", rd, 0);
    chk("R5 main never ch15", 32'(rs[15] | ws[15]), 0);

    // R2 / R10 status and lag
    @(negedge clk); ch_irq = 16'h8421;
    repeat (2) @(negedge clk);
    main_xfer(1, 12'hFE0, 32'h0, 4'hF, rs, ws, off, rd);
    chk("R2 status write no strobe", 32'(rs | ws), 0);
    main_xfer(0, 12'hFE0, 0, 4'hF, rs, ws, off, rd);
    chk("R2 status read", rd, 32'h00008421);
    @(negedge clk);
    m_req_valid = 1; m_req_write = 0; m_req_addr = 12'hFE0; ch_irq = 16'h0003;
    @(posedge clk); @(negedge clk); m_req_valid = 0; #1;
    chk("R10 status lags one cycle", m_rsp_rdata, 32'h00008421);
    main_xfer(0, 12'hFE0, 0, 4'hF, rs, ws, off, rd);
    chk("R10 status after lag", rd, 32'h00000003);

    // R5 aux window
    aux_xfer(1, 8'h08, 32'h12345678, 4'hF, rs, ws, rd);
    chk("R5 aux write ch15", 32'(ws), 32'h8000);
    aux_xfer(0, 8'h1C, 0, 4'hF, rs, ws, rd);
    chk("R5 aux read ch15", 32'(rs), 32'h8000);
    chk("R5 aux read data", rd, chan_word(15, 8'h1C));
    aux_xfer(0, 8'h1C, 0, 4'h7, rs, ws, rd);
    chk("R6 aux partial quiet", 32'(rs | ws), 0);

    // R8 simultaneous requests
    @(negedge clk);
    m_req_valid = 1; m_req_write = 0; m_req_addr = 12'h540; m_req_strb = 4'hF;
    a_req_valid = 1; a_req_write = 0; a_req_addr = 8'h44; a_req_strb = 4'hF;
    #1;
    chk("R8 main ready", 32'(m_req_ready), 1);
    chk("R8 aux waits", 32'(a_req_ready), 0);
    chk("R8 main strobe first", 32'(ch_rd), 32'h0020);
    @(posedge clk); @(negedge clk);
    m_req_valid = 0; #1;
    chk("R8 main data", m_rsp_rdata, chan_word(5, 8'h40));
    chk("R8 aux ready now", 32'(a_req_ready), 1);
    chk("R8 aux strobe", 32'(ch_rd), 32'h8000);
    @(posedge clk); @(negedge clk);
    a_req_valid = 0; #1;
    chk("R8 aux data", a_rsp_rdata, chan_word(15, 8'h44));

    // R9 back-pressure with pending aux request
    @(negedge clk);
    m_rsp_ready = 0; m_req_valid = 1; m_req_addr = 12'h110; m_req_write = 0;
    @(posedge clk); @(negedge clk);
    m_req_addr = 12'h220; a_req_valid = 1; a_req_addr = 8'h04; #1;
    chk("R9 stalled not ready", 32'(m_req_ready), 0);
    chk("R9 aux still blocked", 32'(a_req_ready), 0);
    chk("R9 no strobe while stalled", 32'(ch_rd | ch_wr), 0);
    @(posedge clk); @(negedge clk); #1;
    chk("R9 held valid", 32'(m_rsp_valid), 1);
    chk("R9 held data", m_rsp_rdata, chan_word(1, 8'h10));
    m_rsp_ready = 1; #1;
    chk("R9 ready on release", 32'(m_req_ready), 1);
    @(posedge clk); @(negedge clk);
    m_req_valid = 0; #1;
    chk("R9 next data", m_rsp_rdata, chan_word(2, 8'h20));
    @(posedge clk); @(negedge clk);
    a_req_valid = 0; #1;
    chk("R9 aux after release", a_rsp_rdata, chan_word(15, 8'h04));

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule